// File: doc/BRIEF.md
# Privilege-Gated Flash Protection Range Register

This block holds the bounds of one write-protected flash region: a first page and a last page, each a 7-bit number of a 2-Kbyte page. Both bounds sit in one 32-bit word that the bus can read and write. The block also checks a flash address against the region and reports whether the address lies inside it.

After reset the bounds take values that mark the region as empty. A dedicated load strobe then replaces both bounds with the values held in non-volatile option storage. The load is not subject to any access check, and it wins over a bus write that arrives in the same cycle.

A bus write must pass three checks before it is committed. It must come from the primary CPU master. The readout-protection level must be 0 or 1. When secure mode and privilege protection are both on, the access must also be privileged. A write that fails any check is dropped and raises a one-cycle illegal-access pulse. Reads are never gated.

Top module: `prot_range_reg`

## Requirements
- R1: After reset `rd_data` reads 0xFF80_FFFF. The first page is 127 and the last page is 0.
- R2: The last page sits in bits 22:16 and the first page in bits 6:0. Every other bit always reads 1, and writing to those bits has no effect.
- R3: On an accepted write, `bus_be[0]` loads the first page from `bus_wdata[6:0]` and `bus_be[2]` loads the last page from `bus_wdata[22:16]`. A field whose enable is low keeps its value. `bus_be[1]` and `bus_be[3]` change nothing.
- R4: A write is accepted only when `bus_master` equals PRIMARY_ID (default 0) and `rp_level` is 2'b00 or 2'b01. A write with any other master, or with level 2'b10 or 2'b11, leaves the register unchanged.
- R5: When `secure_en` and `priv_prot_en` are both 1, a write also needs `bus_priv`=1 to be accepted. In every other case `bus_priv` has no effect on writes.
- R6: A write that is rejected leaves `rd_data` unchanged. It makes `illegal_evt` high for exactly the next cycle. `illegal_evt` is high in no other cycle.
- R7: `rd_data` always shows the current register value, whatever the master, the privilege and the protection level.
- R8: `range_hit` is a combinational output. It is 1 exactly when page = `chk_addr[17:11]` satisfies first ≤ page ≤ last, with both bounds included.
- R9: When the first page is greater than the last page, `range_hit` is 0 for every address.
- R10: A cycle with `opt_load`=1 sets both pages from `opt_start` and `opt_end`, whatever the access conditions. It overrides a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opt_load | input | 1 | Strobe that loads both bounds from option storage |
| opt_start | input | 7 | First page value to load |
| opt_end | input | 7 | Last page value to load |
| bus_wr | input | 1 | Write request |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_master | input | 2 | Identity of the requesting master |
| bus_priv | input | 1 | 1 when the access is privileged |
| rp_level | input | 2 | Readout-protection level, 0 to 3 |
| secure_en | input | 1 | Secure mode enable |
| priv_prot_en | input | 1 | Privilege protection enable |
| chk_addr | input | 32 | Flash address checked against the region |
| rd_data | output | 32 | Current register value |
| illegal_evt | output | 1 | One-cycle pulse after a rejected write |
| range_hit | output | 1 | 1 when `chk_addr` lies inside the region |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an option load and a bus write. The bench drives a rejected write together with `opt_load`, and also an accepted write together with `opt_load`. It expects the loaded bounds in both cases, and it expects the illegal pulse only for the rejected write. The second pair is a change of bounds and a range check. The bench holds `chk_addr` on a page at a boundary while a write moves that bound. It then expects `range_hit` to follow the new bounds in the cycle right after the edge.

// File: rtl/prot_range_pkg.sv
package prot_range_pkg;

  localparam int REG_W = 32;
  localparam int BE_W  = REG_W / 8;

  // Levels 0 and 1 allow writes; levels 2 and 3 block them.
  function automatic logic level_allows(input logic [1:0] lvl);
    return (lvl == 2'b00) || (lvl == 2'b01);
  endfunction

  // Privilege is needed only when secure mode and privilege protection are both on.
  function automatic logic priv_allows(input logic sec, input logic pp, input logic priv);
    return !(sec && pp) || priv;
  endfunction

  // Inclusive bounds test; an inverted pair gives no match.
  function automatic logic page_inside(input logic [7:0] page, input logic [7:0] lo,
                                       input logic [7:0] hi);
    return (lo <= page) && (page <= hi);
  endfunction

endpackage

// File: rtl/prot_access_gate.sv
module prot_access_gate
  import prot_range_pkg::*;
#(
  parameter int MID_W      = 2,
  parameter int PRIMARY_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [MID_W-1:0] master,
  input  logic [1:0]       lvl,
  input  logic             sec,
  input  logic             pp,
  input  logic             priv,
  output logic             grant,
  output logic             reject,
  output logic             evt
);
  localparam logic [MID_W-1:0] PRIMARY = MID_W'(PRIMARY_ID);

  logic master_ok;
  logic checks_ok;

  assign master_ok = (master == PRIMARY);
  assign checks_ok = master_ok && level_allows(lvl) && priv_allows(sec, pp, priv);
  assign grant     = req && checks_ok;
  assign reject    = req && !checks_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= reject;
  end
endmodule

// File: rtl/prot_field_reg.sv
module prot_field_reg
  import prot_range_pkg::*;
#(
  parameter int             W   = 7,
  parameter int             POS = 0,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [W-1:0]      load_val,
  input  logic              wr,
  input  logic [BE_W-1:0]   be,
  input  logic [REG_W-1:0]  wdata,
  output logic [W-1:0]      q
);
  localparam int LANE = POS / 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= RST;
    else if (load)             q <= load_val;
    else if (wr && be[LANE])   q <= wdata[POS +: W];
  end
endmodule

// File: rtl/prot_page_match.sv
module prot_page_match
  import prot_range_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 7,
  parameter int PAGE_LSB = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] lo,
  input  logic [PAGE_W-1:0] hi,
  output logic              hit
);
  logic [PAGE_W-1:0] page;

  assign page = addr[PAGE_LSB +: PAGE_W];
  assign hit  = page_inside(8'(page), 8'(lo), 8'(hi));
endmodule

// File: rtl/prot_range_reg.sv
module prot_range_reg
  import prot_range_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_W     = 7,
  parameter int PAGE_LSB   = 11,
  parameter int LO_POS     = 0,
  parameter int HI_POS     = 16,
  parameter int MID_W      = 2,
  parameter int PRIMARY_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_load,
  input  logic [PAGE_W-1:0] opt_start,
  input  logic [PAGE_W-1:0] opt_end,
  input  logic              bus_wr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [MID_W-1:0]  bus_master,
  input  logic              bus_priv,
  input  logic [1:0]        rp_level,
  input  logic              secure_en,
  input  logic              priv_prot_en,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              illegal_evt,
  output logic              range_hit
);
  localparam logic [REG_W-1:0] FIELD_ONES = REG_W'((1 << PAGE_W) - 1);
  localparam logic [REG_W-1:0] LO_MASK    = FIELD_ONES << LO_POS;
  localparam logic [REG_W-1:0] HI_MASK    = FIELD_ONES << HI_POS;
  localparam logic [REG_W-1:0] RSVD_MASK  = ~(LO_MASK | HI_MASK);

  // Named internal events, brought out for the checker.
  logic              wr_ok;
  logic              wr_rej;
  logic [PAGE_W-1:0] page_lo;
  logic [PAGE_W-1:0] page_hi;

  prot_access_gate #(.MID_W(MID_W), .PRIMARY_ID(PRIMARY_ID)) u_gate (
    .clk(clk), .rst_n(rst_n), .req(bus_wr), .master(bus_master), .lvl(rp_level),
    .sec(secure_en), .pp(priv_prot_en), .priv(bus_priv),
    .grant(wr_ok), .reject(wr_rej), .evt(illegal_evt)
  );

  prot_field_reg #(.W(PAGE_W), .POS(LO_POS), .RST({PAGE_W{1'b1}})) u_lo (
    .clk(clk), .rst_n(rst_n), .load(opt_load), .load_val(opt_start),
    .wr(wr_ok), .be(bus_be), .wdata(bus_wdata), .q(page_lo)
  );

  prot_field_reg #(.W(PAGE_W), .POS(HI_POS), .RST({PAGE_W{1'b0}})) u_hi (
    .clk(clk), .rst_n(rst_n), .load(opt_load), .load_val(opt_end),
    .wr(wr_ok), .be(bus_be), .wdata(bus_wdata), .q(page_hi)
  );

  prot_page_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)) u_match (
    .addr(chk_addr), .lo(page_lo), .hi(page_hi), .hit(range_hit)
  );

  assign rd_data = RSVD_MASK
                 | (REG_W'(page_lo) << LO_POS)
                 | (REG_W'(page_hi) << HI_POS);
endmodule

// File: rtl/prot_range_chk.sv
module prot_range_chk
  import prot_range_pkg::*;
#(
  parameter int PAGE_W     = 7,
  parameter int LO_POS     = 0,
  parameter int HI_POS     = 16,
  parameter int MID_W      = 2,
  parameter int PRIMARY_ID = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opt_load,
  input logic [PAGE_W-1:0] opt_start,
  input logic [PAGE_W-1:0] opt_end,
  input logic [MID_W-1:0]  bus_master,
  input logic [1:0]        rp_level,
  input logic [REG_W-1:0]  rd_data,
  input logic              illegal_evt,
  input logic              range_hit,
  input logic              wr_ok,
  input logic              wr_rej
);
  localparam logic [REG_W-1:0] FIELD_ONES = REG_W'((1 << PAGE_W) - 1);
  localparam logic [REG_W-1:0] FIELDS     = (FIELD_ONES << LO_POS) | (FIELD_ONES << HI_POS);

  logic [PAGE_W-1:0] lo_v, hi_v;
  assign lo_v = rd_data[LO_POS +: PAGE_W];
  assign hi_v = rd_data[HI_POS +: PAGE_W];

  assert_rsvd_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    &(rd_data | FIELDS));

  assert_accept_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (bus_master == MID_W'(PRIMARY_ID)) && (rp_level[1] == 1'b0));

  assert_rej_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rej |=> illegal_evt);

  assert_evt_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_evt |-> $past(wr_rej));

  assert_rej_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rej && !opt_load) |=> $stable(rd_data));

  assert_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_v > hi_v) |-> !range_hit);

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    opt_load |=> (lo_v == $past(opt_start)) && (hi_v == $past(opt_end)));
endmodule

bind prot_range_reg prot_range_chk #(
  .PAGE_W(PAGE_W), .LO_POS(LO_POS), .HI_POS(HI_POS),
  .MID_W(MID_W), .PRIMARY_ID(PRIMARY_ID)
) u_chk (.*);

// File: tb/sim_prot_range_reg.sv
`timescale 1ns/1ps
module sim_prot_range_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opt_load = 1'b0;
  logic [6:0]  opt_start = '0, opt_end = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_master = '0;
  logic        bus_priv = 1'b0;
  logic [1:0]  rp_level = '0;
  logic        secure_en = 1'b0, priv_prot_en = 1'b0;
  logic [31:0] chk_addr = '0;
  logic [31:0] rd_data;
  logic        illegal_evt, range_hit;

  int errors = 0, checks = 0;
  bit done = 0;
  int m_lo = 127, m_hi = 0;
  bit m_evt = 0;

  always #2 clk = ~clk;

  prot_range_reg u0 (.*);

  function automatic bit accepted();
    return (bus_master == 0) && (rp_level < 2) &&
           (!(secure_en && priv_prot_en) || bus_priv);
  endfunction

  function automatic bit want_hit();
    int pg = (chk_addr / 2048) % 128;
    return (m_lo <= pg) && (pg <= m_hi);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] e = 32'hFF80_FF80 | 32'(m_lo) | (32'(m_hi) << 16);
    check({tag, " rd_data"}, rd_data, e);
    check({tag, " illegal_evt"}, 32'(illegal_evt), 32'(m_evt));
    check({tag, " range_hit"}, 32'(range_hit), 32'(want_hit()));
  endtask

  // One clock: model updates at the edge, outputs are compared at the falling edge.
  task automatic step(input string tag);
    @(posedge clk);
    m_evt = bus_wr && !accepted();
    if (opt_load) begin
      m_lo = opt_start; m_hi = opt_end;
    end else if (bus_wr && accepted()) begin
      if (bus_be[0]) m_lo = bus_wdata[6:0];
      if (bus_be[2]) m_hi = bus_wdata[22:16];
    end
    @(negedge clk);
    bus_wr = 0; opt_load = 0;
    compare(tag);
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    bus_wr = 1; bus_be = be; bus_wdata = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after release");

    wr(4'hF, 32'h0000_0000 | (32'd40 << 16) | 32'd10); step("R3 R4 word write");
    chk_addr = 32'd10 * 2048; step("R8 low edge");
    chk_addr = 32'd40 * 2048 + 2047; step("R8 high edge");
    chk_addr = 32'd41 * 2048; step("R8 above");
    chk_addr = 32'd9 * 2048 + 5; step("R8 below");
    wr(4'b0001, 32'h00FF_FF05); step("R3 byte0 only");
    wr(4'b0100, 32'h0033_0077); step("R3 byte2 only");
    wr(4'b1010, 32'h0000_0000); step("R2 R3 reserved lanes");
    wr(4'hF, 32'h0000_0000); step("R2 zeros to reserved");
    bus_master = 1; wr(4'hF, 32'h0011_0011); step("R4 R6 wrong master");
    step("R6 pulse ends");
    bus_master = 0; rp_level = 2; wr(4'hF, 32'h0011_0011); step("R4 level2");
    rp_level = 3; wr(4'hF, 32'h0011_0011); step("R4 level3");
    rp_level = 1; wr(4'hF, 32'h0022_0002); step("R4 level1 ok");
    secure_en = 1; priv_prot_en = 1; bus_priv = 0;
    wr(4'hF, 32'h0050_0003); step("R5 R6 unprivileged");
    bus_priv = 1; wr(4'hF, 32'h0050_0003); step("R5 privileged");
    priv_prot_en = 0; bus_priv = 0; wr(4'hF, 32'h0060_0004); step("R5 no priv prot");
    secure_en = 0; priv_prot_en = 1; wr(4'hF, 32'h0061_0005); step("R5 not secure");
    bus_priv = 1; bus_master = 2; step("R7 read unaffected");
    bus_master = 0;
    wr(4'hF, 32'h0005_0009); chk_addr = 32'd7 * 2048; step("R9 inverted");
    chk_addr = 32'd9 * 2048; step("R9 at start");
    chk_addr = 32'd5 * 2048; step("R9 at end");
    opt_load = 1; opt_start = 7'd20; opt_end = 7'd30; rp_level = 2;
    wr(4'hF, 32'h0001_0001); step("R10 load over rejected write");
    opt_load = 1; opt_start = 7'd0; opt_end = 7'd127; rp_level = 0;
    wr(4'hF, 32'h0001_0001); step("R10 load over accepted write");
    chk_addr = 32'd127 * 2048; step("R8 full range top");
    chk_addr = 32'd30 * 2048; wr(4'b0100, 32'h001D_0000); step("R8 bound moves");

    for (int i = 0; i < 3000; i++) begin
      bus_wr = $urandom_range(0, 1);
      bus_be = 4'($urandom);
      bus_wdata = $urandom;
      bus_master = 2'($urandom_range(0, 3) == 0 ? 1 : 0);
      bus_priv = $urandom_range(0, 1);
      rp_level = 2'($urandom_range(0, 3) == 0 ? 2 : $urandom_range(0, 1));
      secure_en = $urandom_range(0, 1);
      priv_prot_en = $urandom_range(0, 1);
      opt_load = ($urandom_range(0, 15) == 0);
      opt_start = 7'($urandom);
      opt_end = 7'($urandom);
      chk_addr = $urandom;
      step("R3 R4 R5 R6 R8 R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule